// File: doc/BRIEF.md
# Panel Pixel Output Formatter

This block sits between a recovered video stream and a flat-panel data port. It takes one pixel per pixel tick together with data enable, two sync lines and a small control field. It presents them to the panel either one pixel per output word or as an even/odd pixel pair per word. It also generates the panel clock. That clock can run freely or be held low outside active video, and its polarity sets which edge the panel should latch on. In pair mode the even half can be issued one core cycle later than the rest of the word, so the two halves do not switch together.

The block runs on one core clock `clk` at twice the pixel rate. `pixTick` marks the core cycle that carries a new pixel. Every pad is modelled as a value plus an output enable. An output-disable input removes the enables from the data, sync, clock and most control outputs, and leaves the link-status line and one control bit driven. A power-down input removes every enable, clears all state and ignores the inputs. A link detector reports whether data enable is still toggling.

Top module: `pix_out_formatter`

## Requirements
- R1: With `twoPix` low, a pixel presented with `pixTick` appears on `evenBus` after the clock edge that samples it, with `oddBus` = 0. `deOut`/`hsOut`/`vsOut`/`ctlOut` carry that pixel's side signals, and each word stays until the next tick.
- R2: With `twoPix` high, pixels are grouped in pairs and the word updates at the tick of the second pixel. The second pixel goes to `oddBus`, the first to `evenBus`, and the side signals come from the first pixel. The first pixel after a rising `deIn` is always a first (even) pixel. A half-formed pair still pending at that rise is flushed as its own word with `oddBus` = 0.
- R3: In pair mode, when data enable falls after an even pixel, the next tick issues that pixel on `evenBus` with `oddBus` = 0 and `deOut` = 1.
- R4: With `clkInv` low, `oclk` is low during the first core cycle after a word update and high during the second (single mode). In pair mode it is low for two core cycles and high for two, so its period is two pixels.
- R5: `clkInv` high inverts `oclk`, which moves the mid-word latching edge from rising to falling.
- R6: With `gateClk` high, `oclk` is held low whenever `deOut` is low.
- R7: With `twoPix` high and `stagN` low, `evenBus` takes its new value one core cycle (a quarter output period) after `oddBus` and the side outputs. With `stagN` high, or in single mode, there is no such delay.
- R8: With `pdoN` low and `pdN` high, `busOe` is 0, `ctlOe` is 4'b0010 (only control bit 1 enabled), and `linkOe` is 1. The internal logic, including `linkUp`, keeps running.
- R9: With `pdN` low, every enable is 0, all state clears to zero, and pixel, enable and sync inputs have no effect.
- R10: After `pdN` returns high, the first pixel goes to the even half in pair mode.
- R11: At each tick a change of `deIn` from its previously ticked value sets `linkUp`. After TIMEOUT consecutive ticks without a change, `linkUp` clears (31 quiet ticks keep it high and the 32nd clears it, with default TIMEOUT = 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, twice the pixel rate |
| rstN | input | 1 | Asynchronous reset, active low |
| pixTick | input | 1 | Marks the cycle carrying a new pixel |
| pixIn | input | PIX_W | Pixel data |
| deIn | input | 1 | Data enable |
| hsIn | input | 1 | Horizontal sync |
| vsIn | input | 1 | Vertical sync |
| ctlIn | input | CTL_W | Control field |
| twoPix | input | 1 | 1 = two pixels per word |
| clkInv | input | 1 | 1 = panel latches on falling edge |
| gateClk | input | 1 | 1 = output clock held low in blanking |
| stagN | input | 1 | 0 = stagger even half in pair mode |
| pdoN | input | 1 | 0 = disable most output drivers |
| pdN | input | 1 | 0 = full power-down |
| evenBus | output | PIX_W | Even (or only) pixel |
| oddBus | output | PIX_W | Odd pixel |
| deOut | output | 1 | Word data enable |
| hsOut | output | 1 | Word horizontal sync |
| vsOut | output | 1 | Word vertical sync |
| ctlOut | output | CTL_W | Word control field |
| oclk | output | 1 | Panel clock |
| linkUp | output | 1 | Data-enable activity status |
| busOe | output | 1 | Enable for data, sync, de and clock pads |
| ctlOe | output | CTL_W | Per-bit enable for control pads |
| linkOe | output | 1 | Enable for the status pad |

## Verification
The bench runs lines of odd and even length in both word modes. A wrong pad rule would leave a stale odd pixel after a line that ends on an even pixel. A lost flush at the rise of data enable would put the first active pixel on the odd bus. The bench samples the staggered even bus both one cycle after the word edge and one cycle later. An unstaggered or doubly delayed even bus fails at one of those two points. Power-down is entered with a half-built pair pending and released with data enable already high, so a design that keeps its pairing phase or its previous enable value misplaces the first pixel. The link timeout is probed one tick before and at expiry to catch an off-by-one counter.

// File: rtl/pof_pkg.sv
package pof_pkg;

  // Strobes the control half sends to the datapath each cycle.
  typedef struct packed {
    logic clear;    // power-down: wipe all state
    logic oneMode;  // single-pixel word format
    logic capture;  // store current pixel as pending even half
    logic emit;     // load a new output word
    logic padOdd;   // odd half of the emitted word is zero
  } strobe_t;

endpackage

// File: rtl/pof_ctrl.sv
module pof_ctrl
  import pof_pkg::*;
#(
  parameter int TIMEOUT = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pixTick,
  input  logic    deIn,
  input  logic    twoPix,
  input  logic    clkInv,
  input  logic    gateClk,
  input  logic    pdN,
  input  logic    wordDe,
  output strobe_t stb,
  output logic    oclk,
  output logic    linkUp
);

  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic          dePrev;
  logic          pairOdd;
  logic [1:0]    slot;
  logic [CW-1:0] idleCnt;
  logic          tickOk;
  logic          deRise;
  logic          deEdge;
  logic          clkRaw;

  assign tickOk = pixTick & pdN;
  assign deRise = deIn & ~dePrev;
  assign deEdge = deIn ^ dePrev;

  // Strobe generation for the demultiplexer
  always_comb begin
    stb         = '0;
    stb.clear   = ~pdN;
    stb.oneMode = ~twoPix;
    if (tickOk) begin
      if (!twoPix) begin
        stb.emit = 1'b1;
      end else if (!pairOdd) begin
        stb.capture = 1'b1;
      end else begin
        stb.emit = 1'b1;
        if (deRise) begin
          stb.padOdd  = 1'b1;
          stb.capture = 1'b1;
        end else if (!deIn) begin
          stb.padOdd = 1'b1;
        end
      end
    end
  end

  // Pair phase and previous enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dePrev  <= 1'b0;
      pairOdd <= 1'b0;
    end else if (!pdN) begin
      dePrev  <= 1'b0;
      pairOdd <= 1'b0;
    end else if (pixTick) begin
      dePrev <= deIn;
      if (!twoPix)      pairOdd <= 1'b0;
      else if (!pairOdd) pairOdd <= 1'b1;
      else              pairOdd <= deRise;
    end
  end

  // Output clock phase counter, restarted by every word update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         slot <= '0;
    else if (!pdN)     slot <= '0;
    else if (stb.emit) slot <= '0;
    else               slot <= slot + 2'd1;
  end

  assign clkRaw = twoPix ? slot[1] : slot[0];
  assign oclk   = (gateClk && !wordDe) ? 1'b0 : (clkRaw ^ clkInv);

  // Link activity detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      linkUp  <= 1'b0;
    end else if (!pdN) begin
      idleCnt <= '0;
      linkUp  <= 1'b0;
    end else if (pixTick) begin
      if (deEdge) begin
        idleCnt <= '0;
        linkUp  <= 1'b1;
      end else if (idleCnt != LAST) begin
        idleCnt <= idleCnt + 1'b1;
      end else begin
        linkUp <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pof_datapath.sv
module pof_datapath
  import pof_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int CTL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             deIn,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic             staggerOn,
  output logic [PIX_W-1:0] evenBus,
  output logic [PIX_W-1:0] oddBus,
  output logic             deOut,
  output logic             hsOut,
  output logic             vsOut,
  output logic [CTL_W-1:0] ctlOut
);

  localparam int SIDE_W = CTL_W + 3;

  logic [SIDE_W-1:0] sideIn;
  logic [SIDE_W-1:0] stageSide;
  logic [SIDE_W-1:0] wordSide;
  logic [PIX_W-1:0]  stageEven;
  logic [PIX_W-1:0]  wordEven;
  logic [PIX_W-1:0]  wordOdd;
  logic [PIX_W-1:0]  evenLate;

  assign sideIn = {ctlIn, vsIn, hsIn, deIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageEven <= '0;
      stageSide <= '0;
      wordEven  <= '0;
      wordOdd   <= '0;
      wordSide  <= '0;
      evenLate  <= '0;
    end else if (stb.clear) begin
      stageEven <= '0;
      stageSide <= '0;
      wordEven  <= '0;
      wordOdd   <= '0;
      wordSide  <= '0;
      evenLate  <= '0;
    end else begin
      if (stb.capture) begin
        stageEven <= pixIn;
        stageSide <= sideIn;
      end
      if (stb.emit) begin
        if (stb.oneMode) begin
          wordEven <= pixIn;
          wordOdd  <= '0;
          wordSide <= sideIn;
        end else begin
          wordEven <= stageEven;
          wordOdd  <= stb.padOdd ? '0 : pixIn;
          wordSide <= stageSide;
        end
      end
      evenLate <= wordEven;
    end
  end

  assign evenBus = staggerOn ? evenLate : wordEven;
  assign oddBus  = wordOdd;
  assign deOut   = wordSide[0];
  assign hsOut   = wordSide[1];
  assign vsOut   = wordSide[2];
  assign ctlOut  = wordSide[SIDE_W-1:3];

endmodule

// File: rtl/pix_out_formatter.sv
module pix_out_formatter
  import pof_pkg::*;
#(
  parameter int PIX_W    = 24,
  parameter int CTL_W    = 4,
  parameter int KEEP_CTL = 1,
  parameter int TIMEOUT  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixTick,
  input  logic [PIX_W-1:0] pixIn,
  input  logic             deIn,
  input  logic             hsIn,
  input  logic             vsIn,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic             twoPix,
  input  logic             clkInv,
  input  logic             gateClk,
  input  logic             stagN,
  input  logic             pdoN,
  input  logic             pdN,
  output logic [PIX_W-1:0] evenBus,
  output logic [PIX_W-1:0] oddBus,
  output logic             deOut,
  output logic             hsOut,
  output logic             vsOut,
  output logic [CTL_W-1:0] ctlOut,
  output logic             oclk,
  output logic             linkUp,
  output logic             busOe,
  output logic [CTL_W-1:0] ctlOe,
  output logic             linkOe
);

  strobe_t stb;
  logic    staggerOn;

  assign staggerOn = twoPix & ~stagN;

  pof_ctrl #(.TIMEOUT(TIMEOUT)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .pixTick (pixTick),
    .deIn    (deIn),
    .twoPix  (twoPix),
    .clkInv  (clkInv),
    .gateClk (gateClk),
    .pdN     (pdN),
    .wordDe  (deOut),
    .stb     (stb),
    .oclk    (oclk),
    .linkUp  (linkUp)
  );

  pof_datapath #(.PIX_W(PIX_W), .CTL_W(CTL_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .pixIn     (pixIn),
    .deIn      (deIn),
    .hsIn      (hsIn),
    .vsIn      (vsIn),
    .ctlIn     (ctlIn),
    .staggerOn (staggerOn),
    .evenBus   (evenBus),
    .oddBus    (oddBus),
    .deOut     (deOut),
    .hsOut     (hsOut),
    .vsOut     (vsOut),
    .ctlOut    (ctlOut)
  );

  // Pad enables: status pads survive output-disable, nothing survives power-down
  assign linkOe = pdN;
  assign busOe  = pdN & pdoN;

  for (genvar g = 0; g < CTL_W; g++) begin : gCtlOe
    if (g == KEEP_CTL) begin : gKeep
      assign ctlOe[g] = linkOe;
    end else begin : gBus
      assign ctlOe[g] = busOe;
    end
  end

endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
  parameter int PIX_W    = 24,
  parameter int CTL_W    = 4,
  parameter int KEEP_CTL = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             pixTick,
  input logic             twoPix,
  input logic             stagN,
  input logic             gateClk,
  input logic             pdN,
  input logic [PIX_W-1:0] evenBus,
  input logic [PIX_W-1:0] oddBus,
  input logic             deOut,
  input logic             oclk,
  input logic             linkUp,
  input logic             busOe,
  input logic [CTL_W-1:0] ctlOe,
  input logic             linkOe
);

  // R1: a single-mode word never carries an odd half
  p_single_odd_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(pixTick && !twoPix && pdN) |-> oddBus == '0);

  // R2: unstaggered words only move at a tick edge
  p_word_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pdN && $past(pdN) && !$past(pixTick) && $stable(twoPix) && $stable(stagN)
     && !(twoPix && !stagN))
    |-> ($stable(evenBus) && $stable(oddBus) && $stable(deOut)));

  // R6: gated clock stays low in blanking
  p_gate_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gateClk && !deOut) |-> !oclk);

  // R8: status pads are enabled whenever the main bus is
  p_oe_order_r8: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (linkOe && ctlOe[KEEP_CTL]));

  // R9: power-down leaves no state behind
  p_pd_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(!pdN) |-> (evenBus == '0 && oddBus == '0 && !deOut && !linkUp));

  // R11: link status only rises at a ticked cycle
  p_link_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> $past(pixTick && pdN));

endmodule

bind pix_out_formatter pof_checker #(
  .PIX_W(PIX_W), .CTL_W(CTL_W), .KEEP_CTL(KEEP_CTL)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .pixTick (pixTick),
  .twoPix  (twoPix),
  .stagN   (stagN),
  .gateClk (gateClk),
  .pdN     (pdN),
  .evenBus (evenBus),
  .oddBus  (oddBus),
  .deOut   (deOut),
  .oclk    (oclk),
  .linkUp  (linkUp),
  .busOe   (busOe),
  .ctlOe   (ctlOe),
  .linkOe  (linkOe)
);

// File: tb/pix_out_formatter_test.sv
module pix_out_formatter_test;

  localparam int PIX_W = 24;
  localparam int CTL_W = 4;

  // Row: [12]=pad expected, [11]=twoPix, [10]=stagN, [9]=clkInv, [8]=gateClk, [7:0]=line length
  localparam logic [12:0] ROWS [7] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd5},
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4},
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd6},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'd7},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd8},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'd5},
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic             pixTick;
  logic [PIX_W-1:0] pixIn;
  logic             deIn, hsIn, vsIn;
  logic [CTL_W-1:0] ctlIn;
  logic             twoPix, clkInv, gateClk, stagN, pdoN, pdN;
  logic [PIX_W-1:0] evenBus, oddBus;
  logic             deOut, hsOut, vsOut;
  logic [CTL_W-1:0] ctlOut;
  logic             oclk, linkUp, busOe, linkOe;
  logic [CTL_W-1:0] ctlOe;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pix_out_formatter uut (
    .clk(clk), .rstN(rstN), .pixTick(pixTick), .pixIn(pixIn), .deIn(deIn),
    .hsIn(hsIn), .vsIn(vsIn), .ctlIn(ctlIn), .twoPix(twoPix), .clkInv(clkInv),
    .gateClk(gateClk), .stagN(stagN), .pdoN(pdoN), .pdN(pdN),
    .evenBus(evenBus), .oddBus(oddBus), .deOut(deOut), .hsOut(hsOut),
    .vsOut(vsOut), .ctlOut(ctlOut), .oclk(oclk), .linkUp(linkUp),
    .busOe(busOe), .ctlOe(ctlOe), .linkOe(linkOe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] pv(int r, int j);
    return PIX_W'((r + 1) * 32'h10_0000 + j * 32'h0101 + 1);
  endfunction

  // Called at a falling edge; returns at the next falling edge (point A)
  task automatic drive(logic de, logic [PIX_W-1:0] p);
    pixTick = 1'b1;
    deIn    = de;
    pixIn   = p;
    ctlIn   = p[3:0];
    hsIn    = p[4];
    vsIn    = p[5];
    @(negedge clk);
    pixTick = 1'b0;
  endtask

  task automatic half();
    @(negedge clk);
  endtask

  task automatic setMode(logic tp, logic sn, logic ci, logic gc);
    twoPix = tp; stagN = sn; clkInv = ci; gateClk = gc;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    pdN = 1'b1; pdoN = 1'b1; pixTick = 1'b0; deIn = 1'b0; pixIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [12:0]      row;
    logic [PIX_W-1:0] t;
    int               len;
    hsIn = 0; vsIn = 0; ctlIn = '0;
    setMode(1'b0, 1'b1, 1'b0, 1'b0);
    rstN = 1'b0; pdN = 1'b1; pdoN = 1'b1; pixTick = 1'b0; deIn = 1'b0; pixIn = '0;
    repeat (2) @(negedge clk);
    // Reset state
    chk("R1 reset even", 32'(evenBus), 0);
    chk("R1 reset odd", 32'(oddBus), 0);
    chk("R1 reset de", 32'(deOut), 0);
    chk("R4 reset oclk", 32'(oclk), 0);
    chk("R11 reset link", 32'(linkUp), 0);
    chk("R8 reset oe", 32'({busOe, ctlOe, linkOe}), 32'h3F);
    rstN = 1'b1;
    @(negedge clk);

    // Table of lines
    for (int r = 0; r < 7; r++) begin
      row = ROWS[r];
      len = int'(row[7:0]);
      setMode(row[11], row[10], row[9], row[8]);
      repeat (4) begin drive(1'b0, '0); half(); end
      for (int j = 0; j < len; j++) begin
        drive(1'b1, pv(r, j));
        if (!row[11]) begin
          t = pv(r, j);
          chk("R1 even", 32'(evenBus), 32'(t));
          chk("R1 odd", 32'(oddBus), 0);
          chk("R1 ctl", 32'(ctlOut), 32'(t[3:0]));
          chk("R1 de", 32'(deOut), 1);
        end else if (j % 2 == 1) begin
          t = pv(r, j - 1);
          chk("R2 odd", 32'(oddBus), 32'(pv(r, j)));
          chk("R2 ctl from even", 32'(ctlOut), 32'(t[3:0]));
          chk("R2 de", 32'(deOut), 1);
          if (!row[10]) chk("R7 even delayed", 32'(evenBus), (j >= 3) ? 32'(pv(r, j - 3)) : 0);
          else          chk("R7 even aligned", 32'(evenBus), 32'(t));
        end
        half();
        if (row[11] && j % 2 == 1) chk("R2 even", 32'(evenBus), 32'(pv(r, j - 1)));
      end
      drive(1'b0, '0);
      if (row[11]) begin
        chk("R3 odd after line", 32'(oddBus), row[12] ? 0 : 32'(pv(r, len - 1)));
        if (row[12]) chk("R3 de on padded", 32'(deOut), 1);
      end else begin
        chk("R1 blank de", 32'(deOut), 0);
      end
      half();
      if (row[11] && row[12]) chk("R3 even on padded", 32'(evenBus), 32'(pv(r, len - 1)));
      repeat (3) begin drive(1'b0, '0); half(); end
    end

    // R4/R5: single-mode clock phase
    for (int inv = 0; inv < 2; inv++) begin
      setMode(1'b0, 1'b1, 1'(inv), 1'b0);
      doReset();
      repeat (3) begin
        drive(1'b1, 24'h55);
        chk(inv ? "R5 single A" : "R4 single A", 32'(oclk), 32'(inv));
        half();
        chk(inv ? "R5 single B" : "R4 single B", 32'(oclk), 32'(1 - inv));
      end
    end

    // R4/R5: pair-mode clock phase
    for (int inv = 0; inv < 2; inv++) begin
      setMode(1'b1, 1'b1, 1'(inv), 1'b0);
      doReset();
      drive(1'b1, 24'h11); half();
      for (int k = 1; k < 7; k++) begin
        drive(1'b1, 24'h11);
        chk(inv ? "R5 pair A" : "R4 pair A", 32'(oclk), 32'(((k % 2) == 0) ^ (inv == 1)));
        half();
        chk(inv ? "R5 pair B" : "R4 pair B", 32'(oclk), 32'(((k % 2) == 0) ^ (inv == 1)));
      end
    end

    // R6: gated clock
    setMode(1'b0, 1'b1, 1'b0, 1'b1);
    doReset();
    drive(1'b1, 24'h21); half();
    chk("R6 active toggles", 32'(oclk), 1);
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, '0);
      chk("R6 gated A", 32'(oclk), 0);
      half();
      chk("R6 gated B", 32'(oclk), 0);
    end

    // R8: output disable keeps status pads and logic alive
    setMode(1'b1, 1'b1, 1'b0, 1'b0);
    doReset();
    pdoN = 1'b0;
    drive(1'b1, 24'h31); half();
    chk("R8 busOe", 32'(busOe), 0);
    chk("R8 ctlOe", 32'(ctlOe), 32'h2);
    chk("R8 linkOe", 32'(linkOe), 1);
    chk("R8 link runs", 32'(linkUp), 1);
    pdoN = 1'b1;

    // R9/R10: power-down with a pending half pair, released with de high
    drive(1'b0, 24'h32); half();
    drive(1'b1, 24'h33); half();
    pdN = 1'b0;
    @(negedge clk);
    chk("R9 all oe off", 32'({busOe, ctlOe, linkOe}), 0);
    for (int k = 0; k < 4; k++) begin
      drive(k[0], 24'h40 + 24'(k)); half();
    end
    chk("R9 even ignored", 32'(evenBus), 0);
    chk("R9 odd ignored", 32'(oddBus), 0);
    chk("R9 link ignored", 32'(linkUp), 0);
    pdN = 1'b1;
    drive(1'b1, 24'h71); half();
    drive(1'b1, 24'h72);
    chk("R10 odd after wake", 32'(oddBus), 32'h72);
    half();
    chk("R10 even after wake", 32'(evenBus), 32'h71);

    // R11: link timeout
    setMode(1'b0, 1'b1, 1'b0, 1'b0);
    doReset();
    drive(1'b1, 24'h1); half();
    chk("R11 link set", 32'(linkUp), 1);
    repeat (31) begin drive(1'b1, 24'h1); half(); end
    chk("R11 link held", 32'(linkUp), 1);
    drive(1'b1, 24'h1); half();
    chk("R11 link timeout", 32'(linkUp), 0);
    drive(1'b0, '0); half();
    chk("R11 link reset by toggle", 32'(linkUp), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule